// File: doc/BRIEF.md
# Single-Bit Bus Serial EEPROM Sequencer

This block is the device-side control logic of a small nonvolatile memory that sits on a processor bus and uses only one bit of the data bus. The host issues ordinary bus read and write cycles using active-low chip enable, output enable and write enable. Commands are not opcodes. They are ordered patterns of single-bit read and write cycles. Addresses and data travel one bit per cycle, most significant bit first.

A reset pattern arms the block. A 16-bit address follows. The host then either reads bytes sequentially or loads up to a 32-byte page and issues a start pattern. A simulated self-timed write then copies the loaded bytes into a behavioural RAM. While that write runs, reads show a busy status.

The bus strobes are synchronised to a system clock. A bus cycle takes effect when its strobes deassert. The data bit is split into an input `dIn`, an output `dOut` and a drive-enable `dOutEn` for the pad.

Top module: `busbit_eeprom`

## Requirements
- R1: Read, write 0, read is the reset pattern. It abandons any read or page load and arms address loading. It sets the write-enable latch only if write protect (`wpN`) is high. After reset, reads return 1 until the full address is loaded.
- R2: The address is the next 16 write cycles, MSB first. Only the low log2(ARRAY_BYTES) bits select a byte, so address 0xF845 reaches byte 0x045 when the array is 2048 bytes.
- R3: Reads after the address return array bits MSB first. After every 8th read the address increments. It rolls over from the top byte to byte 0, so reading from 0xFFFF gives byte 0x7FF and then byte 0x000.
- R4: Writing 1 after a read while reading data ends the read. Later reads return 1, and reads return 1 whenever the block is idle.
- R5: Write cycles directly after the address are page data, 8 bits per byte. The byte position wraps inside the 32-byte page selected by address bits 15..5. A 33rd byte overwrites the first.
- R6: Read, write 1, read after one or more complete bytes starts the nonvolatile write. Only the byte positions that were loaded change in the array.
- R7: If the data ends with a partial byte, the start pattern starts no write and leaves the array unchanged.
- R8: While the write runs (WRITE_CYCLES clocks), reads return 0. When it finishes, reads return 1 and the write-enable latch is cleared.
- R9: While `wpN` is low, the latch is held clear and a start pattern writes nothing. If `wpN` falls during a running write, that write still completes.
- R10: Read, write, write sends the block to idle and clears the latch.
- R11: After page data, read, read, write 1 sends the block to idle without writing.
- R12: A reset pattern issued during a running write does not end it or change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset (power-up) |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| wpN | input | 1 | Active-low write protect |
| dIn | input | 1 | Serial data bit from the bus |
| dOut | output | 1 | Serial data or status bit to the bus |
| dOutEn | output | 1 | High while a read cycle is active; enables the pad driver |

## Verification
The assertions assume well-formed bus cycles. Write enable and output enable are never low together while chip enable is low. Each strobe phase lasts longer than the two-stage synchroniser. The data bit is stable across the release of a write. The bench drives every cycle as four clocks of active strobes followed by four idle clocks, and changes inputs one nanosecond after a clock edge. It never issues overlapping read and write strobes. Under those conditions, each recognised cycle's effect is settled before the next cycle samples `dOut`.

// File: rtl/busbit_pkg.sv
package busbit_pkg;
  localparam int PAGE_BYTES = 32;
  localparam int COL_W      = $clog2(PAGE_BYTES);
  localparam int ADDR_BITS  = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_SEQ, ST_LOAD, ST_START, ST_BUSY
  } seqState_t;

  // history of the most recent bus cycles, used to spot command patterns
  typedef enum logic [2:0] {
    PF_NONE, PF_R, PF_RR, PF_RW0, PF_RW1
  } prefix_t;

  typedef struct packed {
    logic             clrAll;
    logic             addrShift;
    logic             rdAdvance;
    logic             dataShift;
    logic             nvWrite;
    logic [COL_W-1:0] nvIdx;
    logic             bitIn;
  } dpCmd_t;
endpackage

// File: rtl/busbit_dp.sv
module busbit_dp
  import busbit_pkg::*;
#(
  parameter int ARRAY_BYTES = 2048
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCmd_t cmd,
  output logic   addrLast,
  output logic   dataComplete,
  output logic   rdBit
);
  localparam int AW = $clog2(ARRAY_BYTES);

  logic [ADDR_BITS-1:0]  addr;
  logic [ADDR_BITS-1:0]  addrNext;
  logic [4:0]            addrCnt;
  logic [2:0]            bitCnt;
  logic [7:0]            shReg;
  logic [COL_W-1:0]      col;
  logic [PAGE_BYTES-1:0] valid;
  logic                  gotByte;
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [7:0]            mem [ARRAY_BYTES];
  logic [7:0]            memWord;

  assign addrNext     = {addr[ADDR_BITS-2:0], cmd.bitIn};
  assign addrLast     = (addrCnt == 5'd15);
  assign dataComplete = gotByte && (bitCnt == 3'd0);
  assign memWord      = mem[addr[AW-1:0]];
  assign rdBit        = memWord[~bitCnt];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr    <= '0;
      addrCnt <= '0;
      bitCnt  <= '0;
      shReg   <= '0;
      col     <= '0;
      valid   <= '0;
      gotByte <= 1'b0;
    end else if (cmd.clrAll) begin
      addrCnt <= '0;
      bitCnt  <= '0;
      shReg   <= '0;
      valid   <= '0;
      gotByte <= 1'b0;
    end else if (cmd.addrShift) begin
      addr <= addrNext;
      col  <= addrNext[COL_W-1:0];
      if (addrCnt != 5'd16) addrCnt <= addrCnt + 5'd1;
    end else if (cmd.rdAdvance) begin
      bitCnt <= bitCnt + 3'd1;
      if (bitCnt == 3'd7) addr <= addr + 1'b1;
    end else if (cmd.dataShift) begin
      shReg  <= {shReg[6:0], cmd.bitIn};
      bitCnt <= bitCnt + 3'd1;
      if (bitCnt == 3'd7) begin
        valid[col] <= 1'b1;
        col        <= col + 1'b1;
        gotByte    <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.dataShift && bitCnt == 3'd7) pageBuf[col] <= {shReg[6:0], cmd.bitIn};
  end

  always_ff @(posedge clk) begin
    if (cmd.nvWrite && valid[cmd.nvIdx])
      mem[{addr[AW-1:COL_W], cmd.nvIdx}] <= pageBuf[cmd.nvIdx];
  end

  assert_byte_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rdAdvance && bitCnt == 3'd7) |=> addr == $past(addr) + 1'b1);

  assert_load_holds_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dataShift |=> addr == $past(addr));

  assert_copy_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.nvWrite |-> !(cmd.addrShift || cmd.dataShift || cmd.rdAdvance || cmd.clrAll));
endmodule

// File: rtl/busbit_ctrl.sv
module busbit_ctrl
  import busbit_pkg::*;
#(
  parameter int WRITE_CYCLES = 200
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   ceN,
  input  logic   oeN,
  input  logic   weN,
  input  logic   wpN,
  input  logic   dIn,
  input  logic   addrLast,
  input  logic   dataComplete,
  input  logic   rdBit,
  output dpCmd_t cmd,
  output logic   dOut,
  output logic   dOutEn
);
  localparam int BCW = $clog2(WRITE_CYCLES + 1);
  localparam logic [BCW-1:0] PAGE_CNT = BCW'(PAGE_BYTES);
  localparam logic [BCW-1:0] LAST_CNT = BCW'(WRITE_CYCLES - 1);

  logic [4:0] syncA, syncB;
  logic ceS, oeS, weS, wpS, dS;
  logic wrAct, rdAct, wrActQ, rdActQ, dQ, evW, evR;
  seqState_t state, stateN;
  prefix_t   pre, preN;
  logic      wel, welN;
  logic [BCW-1:0] busyCnt, busyCntN;

  assign {ceS, oeS, weS, wpS, dS} = syncB;
  assign wrAct  = !ceS && !weS && oeS;
  assign rdAct  = !ceS && !oeS && weS;
  assign evW    = wrActQ && !wrAct;
  assign evR    = rdActQ && !rdAct;
  assign dOutEn = rdAct;
  assign dOut   = (state == ST_BUSY) ? 1'b0 : (state == ST_SEQ) ? rdBit : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 5'b11110;
      syncB   <= 5'b11110;
      wrActQ  <= 1'b0;
      rdActQ  <= 1'b0;
      dQ      <= 1'b0;
      state   <= ST_IDLE;
      pre     <= PF_NONE;
      wel     <= 1'b0;
      busyCnt <= '0;
    end else begin
      syncA   <= {ceN, oeN, weN, wpN, dIn};
      syncB   <= syncA;
      wrActQ  <= wrAct;
      rdActQ  <= rdAct;
      dQ      <= dS;
      state   <= stateN;
      pre     <= preN;
      wel     <= welN;
      busyCnt <= busyCntN;
    end
  end

  always_comb begin
    stateN    = state;
    preN      = pre;
    welN      = wel;
    busyCntN  = busyCnt;
    cmd       = '0;
    cmd.bitIn = dQ;
    cmd.nvIdx = busyCnt[COL_W-1:0];
    if (state == ST_BUSY) begin
      cmd.nvWrite = busyCnt < PAGE_CNT;
      busyCntN    = busyCnt + 1'b1;
      if (busyCnt == LAST_CNT) begin
        stateN = ST_IDLE;
        welN   = 1'b0;
      end
      if (evR) preN = PF_R;
      else if (evW) preN = PF_NONE;
    end else if (evR) begin
      case (pre)
        PF_RW0: begin
          cmd.clrAll = 1'b1;
          stateN     = ST_ADDR;
          welN       = wpS;
          preN       = PF_NONE;
        end
        PF_RW1: begin
          preN = PF_NONE;
          if (state == ST_START && wel) begin
            stateN   = ST_BUSY;
            busyCntN = '0;
          end else begin
            stateN = ST_IDLE;
            welN   = 1'b0;
          end
        end
        default: begin
          preN          = (pre == PF_NONE) ? PF_R : PF_RR;
          cmd.rdAdvance = (state == ST_SEQ);
        end
      endcase
    end else if (evW) begin
      case (pre)
        PF_R: begin
          if (!dQ) preN = PF_RW0;
          else begin
            preN = PF_RW1;
            if (state == ST_LOAD && dataComplete) stateN = ST_START;
            else begin
              stateN = ST_IDLE;
              welN   = 1'b0;
            end
          end
        end
        PF_RR: begin
          if (!dQ) preN = PF_RW0;
          else begin
            stateN = ST_IDLE;
            welN   = 1'b0;
            preN   = PF_NONE;
          end
        end
        PF_NONE: begin
          case (state)
            ST_ADDR: begin
              cmd.addrShift = 1'b1;
              if (addrLast) stateN = ST_SEQ;
            end
            ST_SEQ, ST_LOAD: begin
              cmd.dataShift = 1'b1;
              stateN        = ST_LOAD;
            end
            default: begin
              stateN = ST_IDLE;
              welN   = 1'b0;
            end
          endcase
        end
        default: begin
          stateN = ST_IDLE;
          welN   = 1'b0;
          preN   = PF_NONE;
        end
      endcase
    end
    if (!wpS) welN = 1'b0;
  end

  assert_protect_clears_latch_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wpS |=> !wel);

  assert_start_needs_latch_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_BUSY) |-> $past(wel));

  assert_finish_clears_latch_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(state == ST_BUSY) |-> !wel);

  assert_busy_not_cut_R12: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && busyCnt != LAST_CNT) |=> state == ST_BUSY);
endmodule

// File: rtl/busbit_eeprom.sv
module busbit_eeprom
  import busbit_pkg::*;
#(
  parameter int ARRAY_BYTES  = 2048,
  parameter int WRITE_CYCLES = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic ceN,
  input  logic oeN,
  input  logic weN,
  input  logic wpN,
  input  logic dIn,
  output logic dOut,
  output logic dOutEn
);
  dpCmd_t cmd;
  logic   addrLast;
  logic   dataComplete;
  logic   rdBit;

  busbit_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .wpN(wpN), .dIn(dIn),
    .addrLast(addrLast), .dataComplete(dataComplete), .rdBit(rdBit),
    .cmd(cmd), .dOut(dOut), .dOutEn(dOutEn)
  );

  busbit_dp #(.ARRAY_BYTES(ARRAY_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .addrLast(addrLast), .dataComplete(dataComplete), .rdBit(rdBit)
  );
endmodule

// File: tb/sim_busbit_eeprom.sv
`timescale 1ns/1ps
module sim_busbit_eeprom;
  logic clk = 1'b0;
  logic rstN, ceN, oeN, weN, wpN, dIn;
  logic dOut, dOutEn;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  busbit_eeprom #(.ARRAY_BYTES(2048), .WRITE_CYCLES(200)) u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .wpN(wpN),
    .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn)
  );

  // {address, data written, data expected on readback}
  localparam logic [31:0] VEC [6] = '{
    32'h0010_A5_A5, 32'h0123_3C_3C, 32'h07FF_81_81,
    32'h0000_5E_5E, 32'hF845_C7_C7, 32'h0200_01_01
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic gap;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic busWr(input logic b);
    dIn = b; ceN = 1'b0; weN = 1'b0;
    gap();
    ceN = 1'b1; weN = 1'b1;
    gap();
  endtask

  task automatic busRd(output logic v);
    ceN = 1'b0; oeN = 1'b0;
    gap();
    v = dOut;
    ceN = 1'b1; oeN = 1'b1;
    gap();
  endtask

  task automatic doReset;
    logic v;
    busRd(v); busWr(1'b0); busRd(v);
  endtask

  task automatic startWrite;
    logic v;
    busRd(v); busWr(1'b1); busRd(v);
  endtask

  task automatic sendAddr(input logic [15:0] a);
    for (int i = 15; i >= 0; i--) busWr(a[i]);
  endtask

  task automatic writeByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) busWr(b[i]);
  endtask

  task automatic readByte(output logic [7:0] b);
    logic v;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      busRd(v);
      b = {b[6:0], v};
    end
  endtask

  task automatic readAt(input logic [15:0] a, output logic [7:0] b);
    doReset(); sendAddr(a); readByte(b);
  endtask

  task automatic waitReady(output logic ok);
    logic v;
    ok = 1'b0;
    for (int k = 0; k < 100 && !ok; k++) begin
      busRd(v);
      if (v) ok = 1'b1;
    end
  endtask

  initial begin
    logic v, ok;
    logic [7:0] rb;
    rstN = 1'b0; ceN = 1'b1; oeN = 1'b1; weN = 1'b1; wpN = 1'b1; dIn = 1'b0;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    gap();

    chk("R1 reset state dOutEn", {7'd0, dOutEn}, 8'd0);
    busRd(v);
    chk("R4 idle read after power-up", {7'd0, v}, 8'd1);
    doReset();
    busRd(v);
    chk("R1 read before address", {7'd0, v}, 8'd1);

    for (int i = 0; i < 6; i++) begin
      doReset(); sendAddr(VEC[i][31:16]); writeByte(VEC[i][15:8]); startWrite();
      busRd(v);
      chk("R8 busy status", {7'd0, v}, 8'd0);
      waitReady(ok);
      chk("R8 ready after write", {7'd0, ok}, 8'd1);
      readAt(VEC[i][31:16], rb);
      chk("R6 R2 table readback", rb, VEC[i][7:0]);
    end

    readAt(16'hFFFF, rb);
    chk("R3 top byte via upper bits", rb, 8'h81);
    readByte(rb);
    chk("R3 rollover to zero", rb, 8'h5E);
    readAt(16'h0045, rb);
    chk("R2 upper address bits ignored", rb, 8'hC7);

    doReset(); sendAddr(16'h031E);
    writeByte(8'h11); writeByte(8'h22); writeByte(8'h33);
    startWrite(); waitReady(ok);
    readAt(16'h0300, rb);
    chk("R5 column wrap to page start", rb, 8'h33);
    readAt(16'h031E, rb);
    chk("R5 first loaded byte", rb, 8'h11);
    readByte(rb);
    chk("R5 second loaded byte", rb, 8'h22);

    doReset(); sendAddr(16'h0380);
    for (int i = 0; i < 33; i++) writeByte(8'h40 + 8'(i));
    startWrite(); waitReady(ok);
    readAt(16'h0380, rb);
    chk("R5 33rd byte overwrites first", rb, 8'h60);
    readByte(rb);
    chk("R5 second byte kept", rb, 8'h41);

    doReset(); sendAddr(16'h0011); writeByte(8'h77); startWrite(); waitReady(ok);
    readAt(16'h0010, rb);
    chk("R6 unloaded byte untouched", rb, 8'hA5);
    readByte(rb);
    chk("R6 loaded byte written", rb, 8'h77);

    doReset(); sendAddr(16'h0010);
    for (int i = 0; i < 5; i++) busWr(1'b0);
    startWrite();
    busRd(v);
    chk("R7 partial byte starts nothing", {7'd0, v}, 8'd1);
    readAt(16'h0010, rb);
    chk("R7 array unchanged", rb, 8'hA5);

    wpN = 1'b0;
    doReset(); sendAddr(16'h0123); writeByte(8'hFF); startWrite();
    busRd(v);
    chk("R9 protected start not busy", {7'd0, v}, 8'd1);
    wpN = 1'b1;
    readAt(16'h0123, rb);
    chk("R9 protected data unchanged", rb, 8'h3C);

    doReset(); sendAddr(16'h0124); writeByte(8'h6B); startWrite();
    wpN = 1'b0;
    waitReady(ok);
    wpN = 1'b1;
    readAt(16'h0124, rb);
    chk("R9 write finishes despite protect", rb, 8'h6B);

    doReset(); sendAddr(16'h0010);
    busRd(v); busWr(1'b0); busWr(1'b0);
    busRd(v);
    chk("R10 read write write goes idle", {7'd0, v}, 8'd1);

    doReset(); sendAddr(16'h0123); writeByte(8'h99);
    busRd(v); busRd(v); busWr(1'b1); busRd(v);
    busRd(v);
    chk("R11 read read write1 not busy", {7'd0, v}, 8'd1);
    readAt(16'h0123, rb);
    chk("R11 array unchanged", rb, 8'h3C);

    readAt(16'h0010, rb);
    chk("R4 byte before end", rb, 8'hA5);
    busWr(1'b1);
    busRd(v);
    chk("R4 read ended returns 1", {7'd0, v}, 8'd1);
    busRd(v);
    chk("R4 still idle", {7'd0, v}, 8'd1);

    doReset(); sendAddr(16'h0200); writeByte(8'h42); startWrite();
    doReset();
    busRd(v);
    chk("R12 reset during write keeps busy", {7'd0, v}, 8'd0);
    waitReady(ok);
    chk("R12 write completes", {7'd0, ok}, 8'd1);
    readAt(16'h0200, rb);
    chk("R12 written data", rb, 8'h42);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule